// File: doc/BRIEF.md
# Output-Compare Channel Bank with Master Override

This block holds a bank of timer channels that watch a shared free-running count. Each channel in output-compare mode compares the count with its own compare value. On equality the channel raises its flag and applies a programmed pin action: nothing, toggle, drive low or drive high. When the flag and the channel's interrupt enable are both set, the channel raises its interrupt request. The count itself comes from outside. The count source pulses `cnt_step_i` in every cycle in which the count takes a new value. Compares are evaluated only in those cycles, so a prescaled count that stays on one value for many clocks produces a single event.

The highest-numbered channel is the master. When it has an event, every output-compare channel whose mask bit is set takes its pin level from the master data vector. This override wins over the channel's own action in the same cycle. Software can also pulse a force vector. This applies the selected channels' actions at once, including the master override when the master is forced, and leaves all flags untouched.

All outputs are registered. A stimulus presented in the cycle before a rising clock edge shows on the outputs just after that edge.

Top module: `ocm_timer`

## Requirements
- R1: While `rst` is high at a rising edge, all pins, flags and interrupt requests become 0.
- R2: A channel with select bit 1 sets its flag when `cnt_step_i` is 1 and `cnt_i` equals its compare value. With `cnt_step_i` at 0 no compare takes place, and no flag or pin changes.
- R3: On a compare event the channel's 2-bit action code acts on its pin: 2'b01 toggles it, 2'b10 drives it to 0, 2'b11 drives it to 1, and 2'b00 leaves it unchanged. Action codes are packed two bits per channel, with channel k at `act_i[2k+1:2k]`.
- R4: A channel with select bit 0 (capture mode) never sets its flag and never changes its pin, even when the count equals its compare value.
- R5: A 1 in `flag_clr_i` clears that channel's flag in the same cycle. When a compare event and a clear fall in the same cycle, the flag stays set.
- R6: `irq_o[k]` equals `flag_o[k]` AND the `ien_i[k]` value of the previous cycle.
- R7: On a master event, every channel with its `mask_i` bit and select bit at 1 drives its pin to the matching `mdata_i` bit. The master is channel NCH-1, whose compare value is at `cmp_i[NCH*CW-1 -: CW]`.
- R8: When a masked channel has its own compare event in the same cycle as the master event, the master data bit decides its pin.
- R9: A 1 in `force_i` applies that output-compare channel's action at the next edge without setting any flag. Forcing the master also applies the mask/data override.
- R10: Software that toggles on compare and advances the compare value by H after each event gets a pin that changes every H count steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | CW | Shared free-running count |
| cnt_step_i | input | 1 | Count took a new value this cycle |
| oc_sel_i | input | NCH | Per-channel mode: 1 output compare, 0 capture |
| act_i | input | 2*NCH | Per-channel action code, channel k at bits 2k+1:2k |
| cmp_i | input | NCH*CW | Compare values, channel k at bits k*CW +: CW |
| mask_i | input | NCH | Channels overridden by a master event |
| mdata_i | input | NCH | Levels taken by overridden channels |
| ien_i | input | NCH | Interrupt enables |
| flag_clr_i | input | NCH | Write-1-to-clear pulses for flags |
| force_i | input | NCH | Force pulses for immediate actions |
| pin_o | output | NCH | Channel output pins |
| flag_o | output | NCH | Channel event flags |
| irq_o | output | NCH | Interrupt requests |

## Verification
Two pairs of functions can land on one edge. The first is the master override and a masked channel's own toggle. The bench puts the same compare value on the master and on a toggling channel whose current pin level is 0, with data bit 0, and judges that the pin stays at 0 while an unmasked channel on the same count still takes its own action. The second is a flag clear and a compare event. The bench pulses a clear on a channel in the very step its compare matches and expects the flag to remain set.

// File: rtl/ocm_pkg.sv
package ocm_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } act_e;

  function automatic logic apply_act(input act_e a, input logic cur);
    logic nxt;
    case (a)
      ACT_TOGGLE: nxt = ~cur;
      ACT_LOW:    nxt = 1'b0;
      ACT_HIGH:   nxt = 1'b1;
      default:    nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/ocm_match.sv
module ocm_match #(
  parameter int CW = 16
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cmp_i,
  input  logic          step_i,
  input  logic          sel_i,
  output logic          hit_o
);
  // equality is only qualified on a count step in compare mode
  always_comb hit_o = step_i & sel_i & (cnt_i == cmp_i);
endmodule

// File: rtl/ocm_master.sv
module ocm_master #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0] hit_i,
  input  logic [NCH-1:0] force_i,
  input  logic [NCH-1:0] sel_i,
  input  logic [NCH-1:0] mask_i,
  output logic [NCH-1:0] ovr_o
);
  localparam int M = NCH - 1;
  logic mevt;

  always_comb begin
    mevt  = sel_i[M] & (hit_i[M] | force_i[M]);
    ovr_o = {NCH{mevt}} & mask_i & sel_i;
  end
endmodule

// File: rtl/ocm_chan.sv
module ocm_chan
  import ocm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_i,
  input  logic       hit_i,
  input  logic       force_i,
  input  logic [1:0] act_i,
  input  logic       ovr_i,
  input  logic       odata_i,
  input  logic       clr_i,
  input  logic       ien_i,
  output logic       pin_o,
  output logic       flag_o,
  output logic       irq_o
);
  logic pin_q, flag_q, irq_q;
  logic pin_d, flag_d;

  always_comb begin
    pin_d = pin_q;
    if (sel_i && (hit_i || force_i)) pin_d = apply_act(act_e'(act_i), pin_q);
    if (ovr_i) pin_d = odata_i;          // master has last word
    flag_d = flag_q & ~clr_i;
    if (hit_i) flag_d = 1'b1;            // event beats clear
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pin_q  <= pin_d;
      flag_q <= flag_d;
      irq_q  <= flag_d & ien_i;
    end
  end

  assign pin_o  = pin_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/ocm_timer.sv
module ocm_timer #(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     cnt_i,
  input  logic              cnt_step_i,
  input  logic [NCH-1:0]    oc_sel_i,
  input  logic [2*NCH-1:0]  act_i,
  input  logic [NCH*CW-1:0] cmp_i,
  input  logic [NCH-1:0]    mask_i,
  input  logic [NCH-1:0]    mdata_i,
  input  logic [NCH-1:0]    ien_i,
  input  logic [NCH-1:0]    flag_clr_i,
  input  logic [NCH-1:0]    force_i,
  output logic [NCH-1:0]    pin_o,
  output logic [NCH-1:0]    flag_o,
  output logic [NCH-1:0]    irq_o
);
  logic [NCH-1:0] hit;
  logic [NCH-1:0] ovr;

  for (genvar k = 0; k < NCH; k++) begin : g_cmp
    ocm_match #(.CW(CW)) match_i (
      .cnt_i  (cnt_i),
      .cmp_i  (cmp_i[k*CW +: CW]),
      .step_i (cnt_step_i),
      .sel_i  (oc_sel_i[k]),
      .hit_o  (hit[k])
    );
  end

  ocm_master #(.NCH(NCH)) master_i (
    .hit_i   (hit),
    .force_i (force_i),
    .sel_i   (oc_sel_i),
    .mask_i  (mask_i),
    .ovr_o   (ovr)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    ocm_chan chan_i (
      .clk     (clk),
      .rst     (rst),
      .sel_i   (oc_sel_i[k]),
      .hit_i   (hit[k]),
      .force_i (force_i[k]),
      .act_i   (act_i[2*k +: 2]),
      .ovr_i   (ovr[k]),
      .odata_i (mdata_i[k]),
      .clr_i   (flag_clr_i[k]),
      .ien_i   (ien_i[k]),
      .pin_o   (pin_o[k]),
      .flag_o  (flag_o[k]),
      .irq_o   (irq_o[k])
    );
  end
endmodule

// File: rtl/ocm_timer_chk.sv
module ocm_timer_chk #(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [CW-1:0]     cnt_i,
  input logic              cnt_step_i,
  input logic [NCH-1:0]    oc_sel_i,
  input logic [2*NCH-1:0]  act_i,
  input logic [NCH*CW-1:0] cmp_i,
  input logic [NCH-1:0]    mask_i,
  input logic [NCH-1:0]    mdata_i,
  input logic [NCH-1:0]    ien_i,
  input logic [NCH-1:0]    flag_clr_i,
  input logic [NCH-1:0]    force_i,
  input logic [NCH-1:0]    pin_o,
  input logic [NCH-1:0]    flag_o,
  input logic [NCH-1:0]    irq_o
);
  localparam int M = NCH - 1;
  logic mhit;
  logic [1:0] act_unused;
  always_comb begin
    mhit = cnt_step_i & oc_sel_i[M] & (cnt_i == cmp_i[M*CW +: CW]);
    act_unused = act_i[1:0];
  end

  // R2 R9
  flag_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_step_i && flag_clr_i == '0) |=> $stable(flag_o));

  // R3 R2
  pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_step_i && force_i == '0) |=> $stable(pin_o));

  // R4
  capture_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    (oc_sel_i != '1) |=> ((flag_o & ~$past(flag_o) & ~$past(oc_sel_i)) == '0));

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (flag_o & $past(ien_i)));

  // R7 R8
  master_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    mhit |=> ((pin_o & $past(mask_i & oc_sel_i)) == $past(mdata_i & mask_i & oc_sel_i)));
endmodule

bind ocm_timer ocm_timer_chk #(.NCH(NCH), .CW(CW)) chk_i (
  .clk(clk), .rst(rst), .cnt_i(cnt_i), .cnt_step_i(cnt_step_i),
  .oc_sel_i(oc_sel_i), .act_i(act_i), .cmp_i(cmp_i), .mask_i(mask_i),
  .mdata_i(mdata_i), .ien_i(ien_i), .flag_clr_i(flag_clr_i),
  .force_i(force_i), .pin_o(pin_o), .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/ocm_timer_tb_top.sv
module ocm_timer_tb_top;
  localparam int NCH = 8;
  localparam int CW  = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic [CW-1:0]     cnt;
  logic              step;
  logic [NCH-1:0]    sel, mask, mdata, ien, clr, frc;
  logic [2*NCH-1:0]  act;
  logic [CW-1:0]     cmp [NCH];
  logic [NCH*CW-1:0] cmp_flat;
  logic [NCH-1:0]    pin, flag, irq;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;   // 125 MHz

  always_comb
    for (int k = 0; k < NCH; k++) cmp_flat[k*CW +: CW] = cmp[k];

  ocm_timer #(.NCH(NCH), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .cnt_i(cnt), .cnt_step_i(step), .oc_sel_i(sel),
    .act_i(act), .cmp_i(cmp_flat), .mask_i(mask), .mdata_i(mdata),
    .ien_i(ien), .flag_clr_i(clr), .force_i(frc),
    .pin_o(pin), .flag_o(flag), .irq_o(irq)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic zero_inputs();
    cnt = '0; step = 0; sel = '0; mask = '0; mdata = '0;
    ien = '0; clr = '0; frc = '0; act = '0;
    for (int k = 0; k < NCH; k++) cmp[k] = 16'h1234;
  endtask

  task automatic do_reset();
    zero_inputs();
    rst = 1; tick(); tick(); rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pins", pin, 0);
    chk("R1 flags", flag, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_actions();
    do_reset();
    sel = 8'h0F;
    act[1:0] = 2'b10; act[3:2] = 2'b11; act[5:4] = 2'b01; act[7:6] = 2'b00;
    for (int k = 0; k < 4; k++) cmp[k] = 16'h0010;
    cnt = 16'h0010; step = 1; tick();
    chk("R3 actions", pin, 8'h06);
    chk("R2 flags set", flag, 8'h0F);
    step = 0; tick();
    chk("R2 no step pins", pin, 8'h06);
    step = 1; tick(); step = 0;
    chk("R3 toggle back", pin, 8'h02);
    ien = 8'h0A; tick();
    chk("R6 irq", irq, 8'h0A);
    clr = 8'h02; tick(); clr = 0;
    chk("R5 clear", flag, 8'h0D);
    tick();
    chk("R6 irq after clear", irq, 8'h08);
    clr = 8'h01; step = 1; tick(); clr = 0; step = 0;
    chk("R5 set wins", flag[0], 1);
  endtask

  task automatic t_capture();
    do_reset();
    act[11:10] = 2'b11; cmp[5] = 16'h0020;
    cnt = 16'h0020; step = 1; tick(); step = 0;
    chk("R4 capture flag", flag, 0);
    chk("R4 capture pin", pin, 0);
    sel = 8'h20; step = 1; tick(); step = 0;
    chk("R2 compare mode pin", pin, 8'h20);
    chk("R2 compare mode flag", flag, 8'h20);
  endtask

  task automatic t_master();
    do_reset();
    sel = 8'hFF; mask = 8'h35; mdata = 8'h15; cmp[7] = 16'h0040;
    cnt = 16'h0040; step = 1; tick(); step = 0;
    chk("R7 override", pin, 8'h15);
    chk("R7 flags", flag, 8'h80);
    mdata = 8'h20; step = 1; tick(); step = 0;
    chk("R7 override 2", pin, 8'h20);
  endtask

  task automatic t_priority();
    do_reset();
    sel = 8'hFF; act[5:4] = 2'b01; act[7:6] = 2'b11;
    cmp[2] = 16'h0050; cmp[3] = 16'h0050; cmp[7] = 16'h0050;
    mask = 8'h04; mdata = 8'h00;
    cnt = 16'h0050; step = 1; tick(); step = 0;
    chk("R8 master wins", pin, 8'h08);
    chk("R8 flags", flag, 8'h8C);
  endtask

  task automatic t_force();
    do_reset();
    sel = 8'hEF; act[3:2] = 2'b11; act[9:8] = 2'b01; act[13:12] = 2'b11;
    frc = 8'h52; tick(); frc = 0;
    chk("R9 force pins", pin, 8'h42);
    chk("R9 no flags", flag, 0);
    sel = 8'hFF; mask = 8'h01; mdata = 8'h01; frc = 8'h80; tick(); frc = 0;
    chk("R9 force master", pin, 8'h43);
    chk("R9 master no flag", flag, 0);
  endtask

  task automatic t_square();
    logic [CW-1:0] nxt;
    logic          exp_pin;
    do_reset();
    sel = 8'h40; act[13:12] = 2'b01; cmp[6] = 16'd5;
    nxt = 16'd5; exp_pin = 0;
    for (int c = 0; c < 40; c++) begin
      cnt = CW'(c); step = 1; tick();
      if (CW'(c) == nxt) begin
        exp_pin = ~exp_pin; nxt = nxt + 16'd5; cmp[6] = nxt;
        chk("R10 square edge", pin[6], exp_pin);
      end
    end
    step = 0;
    chk("R10 toggle count", pin[6], 1);  // 7 toggles across 0..39
  endtask

  initial begin
    rst = 1; zero_inputs();
    t_reset();
    t_actions();
    t_capture();
    t_master();
    t_priority();
    t_force();
    t_square();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule